// File: doc/BRIEF.md
# Hibernate State Controller

This block moves a chip between a working (Active) state and a low-power Hibernate state. A single request bit tells it where to go. A 1 asks for Hibernate. A 0 asks to be awake. A synchronous reset always brings the controller back to Active.

Two configuration bits decide how the controller wakes up:
- One bit chooses the wake path. The controller either returns straight to Active, or it first passes through a startup phase. In that phase it raises a request to an external startup sequencer and waits for that sequencer to report completion.
- The other bit chooses whether a one-cycle register-reset pulse is sent to the register file on the way out.

While the controller is hibernating, it takes over three pins: the system reset pin, the memory-reset pin and the interrupt pin. It drives each of them to a level set by configuration. In every other state it passes the functional values of those pins through, registered.

Top module: `hib_ctrl`

## Requirements
- R1: On a cycle with `rst` high, the next edge puts the controller in Active (`active_o`=1, `hib_o`=0, `startup_req_o`=0, `reg_reset_o`=0), with `rst_n_pin`=0, `memrst_n_pin`=0 and `irq_n_pin` at the idle level (1 by default).
- R2: In Active, `hib_req`=1 at an edge makes `hib_o`=1 and `active_o`=0 after that edge. Exactly one of `hib_o`, `active_o`, `startup_req_o` is high at all times.
- R3: In Hibernate with `cfg_wake_seq`=0, `hib_req`=0 at an edge gives `active_o`=1 after that edge.
- R4: In Hibernate with `cfg_wake_seq`=1, `hib_req`=0 at an edge raises `startup_req_o`. It stays high until an edge sees `startup_done`=1, and after that edge `active_o`=1.
- R5: Leaving Hibernate with `cfg_keep_regs`=0 gives `reg_reset_o`=1 for exactly the one cycle after the leaving edge. With `cfg_keep_regs`=1 no pulse is issued. No pulse ever appears in any other case.
- R6: While `hib_o`=1, `rst_n_pin` equals the `cfg_rst_high` sampled at the previous edge (0 low, 1 high).
- R7: While `hib_o`=1, `memrst_n_pin` equals the `cfg_memrst_high` sampled at the previous edge (0 low, 1 high).
- R8: While `hib_o`=1, `irq_n_pin` follows `func_irq_n` when `cfg_irq_quiet`=0. When `cfg_irq_quiet`=1 it is forced to the idle (no-interrupt) level, 1 by default.
- R9: Outside Hibernate, each pin output equals its functional input from the previous edge.
- R10: In the startup phase a Hibernate request is not acted on. An edge with `startup_done`=1 always goes to Active first, even if `hib_req`=1.
- R11: A reset taken during Hibernate returns to Active with no register-reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hib_req | input | 1 | 1 requests Hibernate, 0 requests awake |
| cfg_wake_seq | input | 1 | 1 = wake through startup phase, 0 = direct |
| cfg_keep_regs | input | 1 | 1 = skip register reset on wake |
| cfg_rst_high | input | 1 | Reset pin level during Hibernate |
| cfg_memrst_high | input | 1 | Memory-reset pin level during Hibernate |
| cfg_irq_quiet | input | 1 | 1 = force interrupt pin idle during Hibernate |
| startup_done | input | 1 | Startup sequencer finished |
| func_rst_n | input | 1 | Functional reset pin value |
| func_memrst_n | input | 1 | Functional memory-reset pin value |
| func_irq_n | input | 1 | Functional interrupt pin value (active low) |
| hib_o | output | 1 | In Hibernate |
| active_o | output | 1 | In Active |
| startup_req_o | output | 1 | Startup sequence requested |
| reg_reset_o | output | 1 | One-cycle register-reset pulse |
| rst_n_pin | output | 1 | Reset pin output |
| memrst_n_pin | output | 1 | Memory-reset pin output |
| irq_n_pin | output | 1 | Interrupt pin output |

## Verification
The bench tests both wake paths, each combined with both settings of the register-keep bit.

- **Stray pulse.** A design that issues the pulse from the wrong state, or holds it for two cycles, would put a stray `reg_reset_o` cycle on the table.
- **Pin timing.** Pin overrides are checked on the exact cycle Hibernate begins and on the cycle it ends. A design that decodes the override from the old state would show functional values one cycle into Hibernate, or hold the override one cycle too long.
- **Startup phase.** The bench requests Hibernate during the startup wait. It also raises `startup_done` together with `hib_req`. A controller that skipped back into Hibernate there would never report Active.
- **Reset during Hibernate.** A reset in the middle of Hibernate must not leave a spurious register-reset pulse behind.

// File: rtl/hib_pkg.sv
package hib_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_HIB    = 2'd1,
    ST_WAKE   = 2'd2
  } hib_state_e;
endpackage

// File: rtl/hib_state_fsm.sv
module hib_state_fsm
  import hib_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hib_req,
  input  logic       wake_seq,
  input  logic       keep_regs,
  input  logic       startup_done,
  output hib_state_e state_q,
  output hib_state_e state_d,
  output logic       reg_reset_q
);
  logic leaving_hib;

  // Next-state decode; the wake phase only exits on completion.
  always_comb begin
    state_d     = state_q;
    leaving_hib = 1'b0;
    unique case (state_q)
      ST_ACTIVE: if (hib_req) state_d = ST_HIB;
      ST_HIB: begin
        if (!hib_req) begin
          leaving_hib = 1'b1;
          state_d     = wake_seq ? ST_WAKE : ST_ACTIVE;
        end
      end
      ST_WAKE:   if (startup_done) state_d = ST_ACTIVE;
      default:   state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_ACTIVE;
      reg_reset_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      reg_reset_q <= leaving_hib && !keep_regs;
    end
  end
endmodule

// File: rtl/hib_pin_hold.sv
module hib_pin_hold #(
  parameter int           NUM_PINS = 3,
  parameter logic [NUM_PINS-1:0] RST_VAL = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hold,
  input  logic [NUM_PINS-1:0] force_en,
  input  logic [NUM_PINS-1:0] force_val,
  input  logic [NUM_PINS-1:0] func_val,
  output logic [NUM_PINS-1:0] pin_q
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)                     pin_q[i] <= RST_VAL[i];
      else if (hold && force_en[i]) pin_q[i] <= force_val[i];
      else                         pin_q[i] <= func_val[i];
    end
  end
endmodule

// File: rtl/hib_ctrl.sv
module hib_ctrl
  import hib_pkg::*;
#(
  parameter logic IRQ_IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic hib_req,
  input  logic cfg_wake_seq,
  input  logic cfg_keep_regs,
  input  logic cfg_rst_high,
  input  logic cfg_memrst_high,
  input  logic cfg_irq_quiet,
  input  logic startup_done,
  input  logic func_rst_n,
  input  logic func_memrst_n,
  input  logic func_irq_n,
  output logic hib_o,
  output logic active_o,
  output logic startup_req_o,
  output logic reg_reset_o,
  output logic rst_n_pin,
  output logic memrst_n_pin,
  output logic irq_n_pin
);
  localparam int NUM_PINS = 3;
  // Pin order in the vectors: [0] reset, [1] memory reset, [2] interrupt.
  localparam logic [NUM_PINS-1:0] PIN_RST_VAL = {IRQ_IDLE_LVL, 1'b0, 1'b0};

  hib_state_e state_q, state_d;
  logic [NUM_PINS-1:0] pins_q;

  hib_state_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .hib_req      (hib_req),
    .wake_seq     (cfg_wake_seq),
    .keep_regs    (cfg_keep_regs),
    .startup_done (startup_done),
    .state_q      (state_q),
    .state_d      (state_d),
    .reg_reset_q  (reg_reset_o)
  );

  // Override is decided from the next state so pins and status move together.
  hib_pin_hold #(.NUM_PINS(NUM_PINS), .RST_VAL(PIN_RST_VAL)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .hold      (state_d == ST_HIB),
    .force_en  ({cfg_irq_quiet, 1'b1, 1'b1}),
    .force_val ({IRQ_IDLE_LVL, cfg_memrst_high, cfg_rst_high}),
    .func_val  ({func_irq_n, func_memrst_n, func_rst_n}),
    .pin_q     (pins_q)
  );

  assign hib_o         = (state_q == ST_HIB);
  assign active_o      = (state_q == ST_ACTIVE);
  assign startup_req_o = (state_q == ST_WAKE);
  assign rst_n_pin     = pins_q[0];
  assign memrst_n_pin  = pins_q[1];
  assign irq_n_pin     = pins_q[2];
endmodule

// File: rtl/hib_ctrl_chk.sv
module hib_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic hib_req,
  input logic cfg_keep_regs,
  input logic cfg_rst_high,
  input logic cfg_memrst_high,
  input logic startup_done,
  input logic hib_o,
  input logic active_o,
  input logic startup_req_o,
  input logic reg_reset_o,
  input logic rst_n_pin,
  input logic memrst_n_pin
);
  AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
    $countones({hib_o, active_o, startup_req_o}) == 1); // R2
  AST_ENTER_HIB: assert property (@(posedge clk) disable iff (rst)
    active_o && hib_req |=> hib_o); // R2
  AST_WAKE_WAIT: assert property (@(posedge clk) disable iff (rst)
    startup_req_o && !startup_done |=> startup_req_o); // R4
  AST_WAKE_DONE: assert property (@(posedge clk) disable iff (rst)
    startup_req_o && startup_done |=> active_o); // R10
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_reset_o |=> !reg_reset_o); // R5
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    reg_reset_o |-> $past(hib_o) && !$past(cfg_keep_regs) && !hib_o); // R5
  AST_RST_PIN_HIB: assert property (@(posedge clk) disable iff (rst)
    hib_o |-> rst_n_pin == $past(cfg_rst_high)); // R6
  AST_MEM_PIN_HIB: assert property (@(posedge clk) disable iff (rst)
    hib_o |-> memrst_n_pin == $past(cfg_memrst_high)); // R7
endmodule

bind hib_ctrl hib_ctrl_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .hib_req         (hib_req),
  .cfg_keep_regs   (cfg_keep_regs),
  .cfg_rst_high    (cfg_rst_high),
  .cfg_memrst_high (cfg_memrst_high),
  .startup_done    (startup_done),
  .hib_o           (hib_o),
  .active_o        (active_o),
  .startup_req_o   (startup_req_o),
  .reg_reset_o     (reg_reset_o),
  .rst_n_pin       (rst_n_pin),
  .memrst_n_pin    (memrst_n_pin)
);

// File: tb/tb_hib_ctrl.sv
`timescale 1ns/1ps
module tb_hib_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hib_req = 0, cfg_wake_seq = 0, cfg_keep_regs = 0;
  logic cfg_rst_high = 0, cfg_memrst_high = 0, cfg_irq_quiet = 0;
  logic startup_done = 0, func_rst_n = 0, func_memrst_n = 0, func_irq_n = 0;
  logic hib_o, active_o, startup_req_o, reg_reset_o;
  logic rst_n_pin, memrst_n_pin, irq_n_pin;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  hib_ctrl dut (
    .clk(clk), .rst(rst), .hib_req(hib_req), .cfg_wake_seq(cfg_wake_seq),
    .cfg_keep_regs(cfg_keep_regs), .cfg_rst_high(cfg_rst_high),
    .cfg_memrst_high(cfg_memrst_high), .cfg_irq_quiet(cfg_irq_quiet),
    .startup_done(startup_done), .func_rst_n(func_rst_n),
    .func_memrst_n(func_memrst_n), .func_irq_n(func_irq_n),
    .hib_o(hib_o), .active_o(active_o), .startup_req_o(startup_req_o),
    .reg_reset_o(reg_reset_o), .rst_n_pin(rst_n_pin),
    .memrst_n_pin(memrst_n_pin), .irq_n_pin(irq_n_pin)
  );

  // stim {hib,wake_seq,keep,crst,cmem,cirq,done,frst,fmem,firq}
  // exp  {hib,act,sreq,rrst,prst,pmem,pirq}
  localparam int NV = 19;
  localparam logic [16:0] VEC [NV] = '{
    17'b0000000101_0100101, // v0  R9 pass-through
    17'b0000000010_0100010, // v1  R9
    17'b1001010010_1000101, // v2  R2 R6 R7 R8 forced irq
    17'b1000100100_1000010, // v3  R6 R7 R8 normal irq
    17'b0000000111_0101111, // v4  R3 R5 pulse
    17'b0000000111_0100111, // v5  R5 pulse ends
    17'b1000010110_1000001, // v6  R2
    17'b0110000100_0010100, // v7  R4 R5 keep: no pulse
    17'b0110000011_0010011, // v8  R4 wait, R9
    17'b0110001111_0100111, // v9  R4 done
    17'b1001100000_1000110, // v10 R6 R7 R8
    17'b0100000001_0011001, // v11 R4 R5 pulse on startup path
    17'b0100001101_0100101, // v12 R4
    17'b1000000111_1000001, // v13 R2
    17'b0110000111_0010111, // v14 R4
    17'b1110000111_0010111, // v15 R10 request ignored in startup
    17'b1110001111_0100111, // v16 R10 done wins
    17'b1000100101_1000011, // v17 R2 R7
    17'b0010000010_0100010  // v18 R3 keep: no pulse
  };

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input logic [6:0] e, input string tag);
    chk("R2", hib_o,         e[6], {tag, " hib_o"});
    chk("R3", active_o,      e[5], {tag, " active_o"});
    chk("R4", startup_req_o, e[4], {tag, " startup_req_o"});
    chk("R5", reg_reset_o,   e[3], {tag, " reg_reset_o"});
    chk("R6", rst_n_pin,     e[2], {tag, " rst_n_pin"});
    chk("R7", memrst_n_pin,  e[1], {tag, " memrst_n_pin"});
    chk("R8", irq_n_pin,     e[0], {tag, " irq_n_pin"});
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk_all(7'b0100001, "R1 reset");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {hib_req, cfg_wake_seq, cfg_keep_regs, cfg_rst_high, cfg_memrst_high,
       cfg_irq_quiet, startup_done, func_rst_n, func_memrst_n, func_irq_n} = VEC[i][16:7];
      @(posedge clk);
      #1;
      chk_all(VEC[i][6:0], $sformatf("vec %0d", i));
    end

    // R11: reset in the middle of Hibernate
    {hib_req, cfg_wake_seq, cfg_keep_regs, cfg_rst_high, cfg_memrst_high,
     cfg_irq_quiet, startup_done, func_rst_n, func_memrst_n, func_irq_n} = 10'b1001110111;
    @(posedge clk); #1;
    chk("R11", hib_o, 1'b1, "entered hib before reset");
    rst = 1'b1; hib_req = 1'b0;
    @(posedge clk); #1;
    chk_all(7'b0100001, "R11 reset in hib");
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R11", reg_reset_o, 1'b0, "no pulse after reset");
    chk("R11", active_o, 1'b1, "active after reset");
    chk("R9", rst_n_pin, 1'b1, "pass-through after reset");

    // R1: reset also clears a pending startup phase
    hib_req = 1'b1; @(posedge clk);
    #1 hib_req = 1'b0; cfg_wake_seq = 1'b1;
    @(posedge clk); #1;
    chk("R4", startup_req_o, 1'b1, "startup before reset");
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1", active_o, 1'b1, "reset leaves startup");
    chk("R1", startup_req_o, 1'b0, "startup req cleared");
    rst = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule